// File: doc/BRIEF.md
# Reset and bus configuration sequencer

This block takes a microcontroller's external bus from reset to its first instruction fetch. A reset can come from the system reset input or from the external active-low reset line. Either one makes the block pull the line low for a fixed number of state times, so a short external pulse becomes a full-length system reset. Once the line is released, the block reads the configuration byte from external memory. It latches the byte into a configuration register and then requests the first instruction word.

The latched byte sets the width of later bus accesses. One bit either locks the bus to 8 bits or lets the bus-width pin decide the width on each access. The other fields are passed on as decoded outputs for the strobe and wait-state logic elsewhere in the chip. A power-down request is granted only when the configuration allows power-down. All sequencing advances on a state-time enable. A reset that arrives while configuration is under way, or after it has finished, starts the whole sequence again.

Top module: `boot_bus_cfg`

## Requirements
- R1: After the system reset, and after every external reset the block accepts, `rst_pull` is high for exactly 16 state-time ticks and then falls.
- R2: After the reset line is released, the first memory request is a read of address 0x2018, made before any instruction fetch. `mem_req` is never high while `rst_pull` is high.
- R3: The configuration read uses a 16-bit access (`mem_wide`=1) if `bus_wide` is high in the cycle the request is issued, and an 8-bit access (`mem_wide`=0) otherwise.
- R4: The configuration fields are taken from the low byte of `mem_rdata` on the acknowledged configuration read. Bits 5:4 give `cfg_rdy_mode`, bit 3 gives `cfg_adv_sel`, bit 2 gives `cfg_wr_mode`, bit 1 gives `cfg_dyn_width` and bit 0 gives `cfg_pdn_en`. Bits 7:6 are discarded. `cfg_valid` goes high when the fields are loaded.
- R5: When `cfg_dyn_width`=0, `acc_wide` is 0 whatever `bus_wide` is. When it is 1, `acc_wide` follows `bus_wide` one clock later. The first fetch request uses the same width rule, applied to the newly read byte.
- R6: On the tick that acknowledges the configuration read, the block raises `fetch_start` for exactly one clock. In that clock `mem_req` is high and `mem_addr` is 0x2080. The fetch request ends on the tick that acknowledges it.
- R7: Until the configuration byte has been latched, `cfg_valid`, every configuration field and `acc_wide` read 0.
- R8: Once latched, the configuration fields keep their value until the next reset. Acknowledges or data on the memory port during normal running do not change them.
- R9: `pdn_grant` goes high, one clock after `pdn_req`, only when `cfg_pdn_en`=1. Otherwise a power-down request is ignored.
- R10: The sequence advances only in clocks where `st_en` is high. With `st_en` held low, a low reset line neither restarts the sequence nor changes any output.
- R11: A low reset line seen on a tick while configuring, fetching or running restarts the sequence. `mem_req` drops, the configuration is cleared and the 16-tick pull-down begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset |
| st_en | input | 1 | State-time tick enable |
| ext_rst_n | input | 1 | Level of the external reset line (active low, wired with `rst_pull`) |
| rst_pull | output | 1 | High while the block pulls the reset line low |
| bus_wide | input | 1 | Bus-width pin: 1 requests a 16-bit access |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | ADDR_W | Memory read address |
| mem_wide | output | 1 | Width of the current request: 1 = 16-bit, 0 = 8-bit |
| mem_ack | input | 1 | Read acknowledge, taken on a tick |
| mem_rdata | input | DATA_W | Read data, configuration byte on the low lane |
| pdn_req | input | 1 | Power-down request |
| pdn_grant | output | 1 | Power-down granted |
| cfg_valid | output | 1 | Configuration byte latched |
| cfg_rdy_mode | output | 2 | Ready-mode control field |
| cfg_adv_sel | output | 1 | Address-valid strobe style select |
| cfg_wr_mode | output | 1 | Write strobe mode select |
| cfg_dyn_width | output | 1 | Dynamic bus width enable |
| cfg_pdn_en | output | 1 | Power-down enable |
| acc_wide | output | 1 | Width to use for normal accesses |
| fetch_start | output | 1 | One-clock pulse when the first fetch is issued |

## Verification
The hardest case to reach is a reset that arrives while the configuration read is still waiting for its acknowledge. The memory model in the bench would normally answer at once. The bench therefore withholds the acknowledge, waits until the request for 0x2018 is outstanding, and then pulls the reset line low. A second awkward case is a low reset line with the tick enable stopped. The bench halts `st_en` while the block is running, holds the line low, and checks that nothing moves until ticks resume. A full sweep of all 64 values of the six configuration bits against both bus-width levels covers the field mapping, width selection and power-down gating.

// File: rtl/boot_pkg.sv
package boot_pkg;

  localparam int CFG_FIELD_W = 6;

  typedef enum logic [2:0] {
    ST_HOLD  = 3'd0,
    ST_WAIT  = 3'd1,
    ST_CFG   = 3'd2,
    ST_FETCH = 3'd3,
    ST_RUN   = 3'd4
  } boot_st_e;

  // Field order matches the byte bit positions 5..0 (decoded by neighbours).
  typedef struct packed {
    logic [1:0] rdy_mode;
    logic       adv_sel;
    logic       wr_mode;
    logic       dyn_width;
    logic       pdn_en;
  } boot_cfg_t;

endpackage

// File: rtl/boot_rst_sync.sv
module boot_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= STAGES'({chain, din});
  end

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/boot_stretch.sv
module boot_stretch #(
  parameter int TICKS = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic start,
  output logic active,
  output logic last
);

  localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;
  localparam logic [CW-1:0] LAST_CNT = CW'(TICKS - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b1;
      cnt    <= '0;
    end else if (start) begin
      active <= 1'b1;
      cnt    <= '0;
    end else if (active && tick) begin
      if (cnt == LAST_CNT) begin
        active <= 1'b0;
        cnt    <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign last = active && (cnt == LAST_CNT);

  // R1: the pull-down only ends on a tick after the full count
  a_r1_full_count: assert property (@(posedge clk) disable iff (rst)
    $fell(active) |-> $past(tick) && ($past(cnt) == LAST_CNT));

  a_r1_count_moves_on_tick: assert property (@(posedge clk) disable iff (rst)
    (active && !tick && !start) |=> $stable(cnt));

endmodule

// File: rtl/boot_cfg_reg.sv
module boot_cfg_reg
  import boot_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      clr,
  input  logic      load,
  input  boot_cfg_t din,
  output boot_cfg_t cfg,
  output logic      valid
);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cfg   <= '0;
      valid <= 1'b0;
    end else if (load && !valid) begin
      cfg   <= din;
      valid <= 1'b1;
    end
  end

  // R8: a latched configuration never changes until cleared
  a_r8_cfg_hold: assert property (@(posedge clk) disable iff (rst)
    (valid && $past(valid)) |-> $stable(cfg));

  // R7: nothing but zeros before the byte is latched
  a_r7_zero_until_valid: assert property (@(posedge clk) disable iff (rst)
    !valid |-> (cfg == '0));

endmodule

// File: rtl/boot_width_sel.sv
module boot_width_sel (
  input  logic clk,
  input  logic rst,
  input  logic ld,
  input  logic ld_dyn,
  input  logic valid,
  input  logic dyn,
  input  logic pin,
  output logic wide_next,
  output logic acc_wide
);

  always_comb begin
    if (ld) wide_next = ld_dyn && pin;
    else    wide_next = valid && dyn && pin;
  end

  always_ff @(posedge clk) begin
    if (rst) acc_wide <= 1'b0;
    else     acc_wide <= wide_next;
  end

  // R5: a wide access always needs the pin high
  a_r5_wide_needs_pin: assert property (@(posedge clk) disable iff (rst)
    acc_wide |-> $past(pin));

  // R5: locked mode stays narrow
  a_r5_locked_narrow: assert property (@(posedge clk) disable iff (rst)
    $past(valid && !dyn && !ld) |-> !acc_wide);

endmodule

// File: rtl/boot_bus_cfg.sv
module boot_bus_cfg
  import boot_pkg::*;
#(
  parameter int ADDR_W        = 16,
  parameter int DATA_W        = 16,
  parameter int STRETCH_TICKS = 16,
  parameter int SYNC_STAGES   = 2,
  parameter logic [ADDR_W-1:0] CFG_ADDR   = 16'h2018,
  parameter logic [ADDR_W-1:0] FETCH_ADDR = 16'h2080
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              st_en,
  input  logic              ext_rst_n,
  output logic              rst_pull,
  input  logic              bus_wide,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_wide,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              pdn_req,
  output logic              pdn_grant,
  output logic              cfg_valid,
  output logic [1:0]        cfg_rdy_mode,
  output logic              cfg_adv_sel,
  output logic              cfg_wr_mode,
  output logic              cfg_dyn_width,
  output logic              cfg_pdn_en,
  output logic              acc_wide,
  output logic              fetch_start
);

  boot_st_e  state;
  boot_cfg_t cfg;
  boot_cfg_t cfg_in;
  logic      line_s;
  logic      busy_state;
  logic      restart;
  logic      stretch_last;
  logic      cfg_load;
  logic      wide_next;
  logic      unused_lanes;

  boot_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (ext_rst_n),
    .dout (line_s)
  );

  assign busy_state = (state == ST_CFG) || (state == ST_FETCH) || (state == ST_RUN);
  assign restart    = st_en && !line_s && busy_state;
  assign cfg_in     = boot_cfg_t'(mem_rdata[CFG_FIELD_W-1:0]);
  assign unused_lanes = ^mem_rdata[DATA_W-1:CFG_FIELD_W];
  assign cfg_load   = st_en && (state == ST_CFG) && mem_ack && !restart;

  boot_stretch #(.TICKS(STRETCH_TICKS)) u_stretch (
    .clk    (clk),
    .rst    (rst),
    .tick   (st_en),
    .start  (restart),
    .active (rst_pull),
    .last   (stretch_last)
  );

  boot_cfg_reg u_cfg (
    .clk   (clk),
    .rst   (rst),
    .clr   (restart),
    .load  (cfg_load),
    .din   (cfg_in),
    .cfg   (cfg),
    .valid (cfg_valid)
  );

  boot_width_sel u_width (
    .clk       (clk),
    .rst       (rst),
    .ld        (cfg_load),
    .ld_dyn    (cfg_in.dyn_width),
    .valid     (cfg_valid),
    .dyn       (cfg.dyn_width),
    .pin       (bus_wide),
    .wide_next (wide_next),
    .acc_wide  (acc_wide)
  );

  assign cfg_rdy_mode  = cfg.rdy_mode;
  assign cfg_adv_sel   = cfg.adv_sel;
  assign cfg_wr_mode   = cfg.wr_mode;
  assign cfg_dyn_width = cfg.dyn_width;
  assign cfg_pdn_en    = cfg.pdn_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_HOLD;
      mem_req     <= 1'b0;
      mem_addr    <= '0;
      mem_wide    <= 1'b0;
      fetch_start <= 1'b0;
      pdn_grant   <= 1'b0;
    end else begin
      fetch_start <= 1'b0;
      pdn_grant   <= pdn_req && cfg_valid && cfg.pdn_en;
      if (restart) begin
        state   <= ST_HOLD;
        mem_req <= 1'b0;
      end else if (st_en) begin
        unique case (state)
          ST_HOLD: begin
            if (stretch_last) state <= ST_WAIT;
          end
          ST_WAIT: begin
            if (line_s) begin
              state    <= ST_CFG;
              mem_req  <= 1'b1;
              mem_addr <= CFG_ADDR;
              mem_wide <= bus_wide;
            end
          end
          ST_CFG: begin
            if (mem_ack) begin
              state       <= ST_FETCH;
              mem_addr    <= FETCH_ADDR;
              mem_wide    <= wide_next;
              fetch_start <= 1'b1;
            end
          end
          ST_FETCH: begin
            if (mem_ack) begin
              state   <= ST_RUN;
              mem_req <= 1'b0;
            end
          end
          default: state <= state;
        endcase
      end
    end
  end

  // R2: no bus activity while the reset line is pulled
  a_r2_quiet_in_reset: assert property (@(posedge clk) disable iff (rst)
    rst_pull |-> !mem_req);

  // R2: every new request sequence opens with the configuration read
  a_r2_cfg_first: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_req) |-> (mem_addr == CFG_ADDR));

  // R3: configuration read width follows the pin at issue
  a_r3_cfg_width: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_req) |-> (mem_wide == $past(bus_wide)));

  // R6: fetch pulse coincides with the fetch address
  a_r6_fetch_addr: assert property (@(posedge clk) disable iff (rst)
    fetch_start |-> (mem_req && (mem_addr == FETCH_ADDR) && cfg_valid));

  // R9: grant only when allowed
  a_r9_pdn_gate: assert property (@(posedge clk) disable iff (rst)
    pdn_grant |-> ($past(pdn_req) && $past(cfg_pdn_en)));

  // R10: no state movement without a tick
  a_r10_tick_only: assert property (@(posedge clk) disable iff (rst)
    !st_en |=> $stable(state));

  // R11: a reset seen on a tick while busy restarts everything
  a_r11_restart: assert property (@(posedge clk) disable iff (rst)
    (st_en && !line_s && busy_state) |=> (rst_pull && !cfg_valid && !mem_req));

endmodule

// File: tb/test_boot_bus_cfg.sv
module test_boot_bus_cfg;

  localparam logic [15:0] CFG_A   = 16'h2018;
  localparam logic [15:0] FETCH_A = 16'h2080;
  localparam int LIMIT = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        st_en = 1'b0;
  logic        drv_n = 1'b1;
  logic        ext_rst_n;
  logic        rst_pull;
  logic        bus_wide = 1'b0;
  logic        mem_req;
  logic [15:0] mem_addr;
  logic        mem_wide;
  logic        mem_ack = 1'b0;
  logic [15:0] mem_rdata = 16'h0;
  logic        pdn_req = 1'b0;
  logic        pdn_grant;
  logic        cfg_valid;
  logic [1:0]  cfg_rdy_mode;
  logic        cfg_adv_sel, cfg_wr_mode, cfg_dyn_width, cfg_pdn_en;
  logic        acc_wide;
  logic        fetch_start;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  logic       tick_on = 1'b1;
  int         div = 0;
  logic       ack_block = 1'b0;
  logic       junk = 1'b0;
  logic [7:0] cur_byte = 8'h00;

  int   pull_ticks = 0, last_stretch = 0, stretch_done = 0;
  int   fs_cnt = 0;
  logic [15:0] fs_addr = '0;
  logic fs_wide = 1'b0, fs_req = 1'b0;
  logic p_pull = 1'b0, p_en = 1'b0, p_rst = 1'b1;

  always #10 clk = ~clk;

  assign ext_rst_n = drv_n & ~rst_pull;

  boot_bus_cfg i_boot_bus_cfg (
    .clk(clk), .rst(rst), .st_en(st_en), .ext_rst_n(ext_rst_n),
    .rst_pull(rst_pull), .bus_wide(bus_wide), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_wide(mem_wide), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .pdn_req(pdn_req), .pdn_grant(pdn_grant),
    .cfg_valid(cfg_valid), .cfg_rdy_mode(cfg_rdy_mode),
    .cfg_adv_sel(cfg_adv_sel), .cfg_wr_mode(cfg_wr_mode),
    .cfg_dyn_width(cfg_dyn_width), .cfg_pdn_en(cfg_pdn_en),
    .acc_wide(acc_wide), .fetch_start(fetch_start)
  );

  // tick generator and memory model, driven after the edge
  always @(posedge clk) begin
    #5;
    if (tick_on) begin
      div   = (div == 2) ? 0 : div + 1;
      st_en = (div == 0);
    end else begin
      st_en = 1'b0;
    end
    if (junk) begin
      mem_ack   = 1'b1;
      mem_rdata = 16'hFFFF;
    end else if (mem_req && !ack_block) begin
      mem_ack   = 1'b1;
      mem_rdata = (mem_addr == CFG_A) ? {~cur_byte, cur_byte} : 16'h5AC3;
    end else begin
      mem_ack = 1'b0;
    end
  end

  // monitor between edges
  always @(negedge clk) begin
    if (p_pull && p_en && !p_rst) pull_ticks++;
    if (!p_pull && rst_pull) pull_ticks = 0;
    if (p_pull && !rst_pull) begin
      last_stretch = pull_ticks;
      stretch_done++;
    end
    if (fetch_start) begin
      fs_cnt++;
      fs_addr = mem_addr;
      fs_wide = mem_wide;
      fs_req  = mem_req;
    end
    p_pull = rst_pull;
    p_en   = st_en;
    p_rst  = rst;
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == LIMIT) begin
      fails++;
      $display("FAIL watchdog: got %0d cycles expected fewer than %0d", cyc, LIMIT);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [5:0] fields();
    return {cfg_rdy_mode, cfg_adv_sel, cfg_wr_mode, cfg_dyn_width, cfg_pdn_en};
  endfunction

  task automatic wait_stretch(input int base);
    for (int i = 0; i < 400; i++) begin
      if (stretch_done > base) break;
      @(negedge clk);
    end
    chk(stretch_done > base, "R1 pull-down ended", stretch_done, base + 1);
    chk(last_stretch == 16, "R1 pull-down length", last_stretch, 16);
  endtask

  task automatic wait_req(input logic level, input string tag);
    for (int i = 0; i < 400; i++) begin
      if (mem_req == level) break;
      @(negedge clk);
    end
    chk(mem_req == level, tag, mem_req, level);
  endtask

  task automatic hold_line_low(input int n);
    drv_n = 1'b0;
    repeat (n) @(negedge clk);
    drv_n = 1'b1;
  endtask

  // full boot after an external reset, with checks along the way
  task automatic boot(input logic [7:0] b, input logic bw);
    int sd0, fs0;
    logic was_valid;
    @(negedge clk);
    was_valid = cfg_valid;
    bus_wide = bw;
    cur_byte = b;
    sd0 = stretch_done;
    hold_line_low(8);
    chk(rst_pull == 1'b1, "R11 pull after restart", rst_pull, 1);
    chk(cfg_valid == 1'b0 && fields() == 6'd0, "R11/R7 cleared", {cfg_valid, fields()}, 0);
    if (!was_valid) chk(1'b0, "R11 prior state not running", 0, 1);
    wait_stretch(sd0);
    fs0 = fs_cnt;
    wait_req(1'b1, "R2 request after release");
    chk(mem_addr == CFG_A, "R2 first address", mem_addr, CFG_A);
    chk(mem_wide == bw, "R3 config width", mem_wide, bw);
    chk(cfg_valid == 1'b0 && acc_wide == 1'b0, "R7 invalid before latch",
        {cfg_valid, acc_wide}, 0);
    wait_req(1'b0, "R6 fetch completes");
    chk(fs_cnt == fs0 + 1, "R6 single fetch pulse", fs_cnt - fs0, 1);
    chk(fs_req && fs_addr == FETCH_A, "R6 fetch address", fs_addr, FETCH_A);
    chk(fs_wide == (b[1] & bw), "R5 fetch width", fs_wide, b[1] & bw);
    chk(cfg_valid && fields() == b[5:0], "R4 field decode", fields(), b[5:0]);
    for (int p = 0; p < 2; p++) begin
      bus_wide = p[0];
      repeat (2) @(negedge clk);
      chk(acc_wide == (b[1] & p[0]), "R5 access width", acc_wide, b[1] & p[0]);
    end
    pdn_req = 1'b1;
    repeat (2) @(negedge clk);
    chk(pdn_grant == b[0], "R9 power-down gate", pdn_grant, b[0]);
    pdn_req = 1'b0;
    repeat (2) @(negedge clk);
    chk(pdn_grant == 1'b0, "R9 grant drops", pdn_grant, 0);
    bus_wide = bw;
  endtask

  initial begin
    cur_byte = 8'h17;
    repeat (4) @(posedge clk);
    #5 rst = 1'b0;
    @(negedge clk);
    chk(rst_pull == 1'b1 && mem_req == 1'b0, "R1 reset state", {rst_pull, mem_req}, 2);
    chk(cfg_valid == 1'b0 && fields() == 6'd0 && acc_wide == 1'b0 && fetch_start == 1'b0,
        "R7 reset state", {cfg_valid, fields(), acc_wide, fetch_start}, 0);
    wait_stretch(0);
    wait_req(1'b1, "R2 power-on request");
    chk(mem_addr == CFG_A, "R2 power-on address", mem_addr, CFG_A);
    wait_req(1'b0, "R6 power-on fetch");
    chk(fields() == 6'h17, "R4 power-on fields", fields(), 6'h17);

    // exhaustive sweep of the six configuration bits and both pin levels
    for (int v = 0; v < 64; v++) begin
      for (int w = 0; w < 2; w++) begin
        boot({v[2:1], v[5:0]}, w[0]);
      end
    end

    // R8: memory port activity while running changes nothing
    boot(8'hED, 1'b1);
    junk = 1'b1;
    repeat (12) @(negedge clk);
    junk = 1'b0;
    repeat (2) @(negedge clk);
    chk(fields() == 6'h2D && cfg_valid, "R8 config held", fields(), 6'h2D);
    chk(mem_req == 1'b0 && fetch_start == 1'b0, "R8 no new request", mem_req, 0);

    // R10: ticks stopped, reset line low, nothing moves
    tick_on = 1'b0;
    repeat (3) @(negedge clk);
    drv_n = 1'b0;
    repeat (20) @(negedge clk);
    chk(rst_pull == 1'b0 && cfg_valid == 1'b1, "R10 no restart without tick",
        {rst_pull, cfg_valid}, 1);
    chk(fields() == 6'h2D, "R10 fields unchanged", fields(), 6'h2D);
    tick_on = 1'b1;
    repeat (10) @(negedge clk);
    chk(rst_pull == 1'b1 && cfg_valid == 1'b0, "R11 restart once ticking",
        {rst_pull, cfg_valid}, 2);
    drv_n = 1'b1;
    cur_byte = 8'h0A;
    bus_wide = 1'b0;
    wait_req(1'b1, "R2 request after tick restart");
    wait_req(1'b0, "R6 fetch after tick restart");
    chk(fields() == 6'h0A, "R4 fields after tick restart", fields(), 6'h0A);

    // R11: reset while the configuration read is outstanding
    ack_block = 1'b1;
    cur_byte = 8'h33;
    hold_line_low(8);
    wait_req(1'b1, "R2 request before stall");
    repeat (12) @(negedge clk);
    chk(mem_req && mem_addr == CFG_A && !cfg_valid, "R11 stalled config read",
        mem_addr, CFG_A);
    hold_line_low(8);
    chk(mem_req == 1'b0 && rst_pull == 1'b1, "R11 mid-config restart",
        {mem_req, rst_pull}, 1);
    chk(cfg_valid == 1'b0, "R11 config still clear", cfg_valid, 0);
    ack_block = 1'b0;
    cur_byte = 8'h26;
    bus_wide = 1'b1;
    wait_req(1'b1, "R2 request after mid-config restart");
    chk(mem_addr == CFG_A && mem_wide == 1'b1, "R3 width after restart", mem_wide, 1);
    wait_req(1'b0, "R6 fetch after mid-config restart");
    chk(fields() == 6'h26 && acc_wide == 1'b1, "R5 dynamic width after restart",
        {fields(), acc_wide}, {6'h26, 1'b1});

    summary();
    $finish;
  end

endmodule